// File: doc/BRIEF.md
# Stack Bytecode Execution Unit

This block interprets a small set of single-byte stack-machine opcodes directly in hardware. A pulse on `start` loads a program counter with `start_pc`. The unit then reads opcodes one byte at a time from a code memory with synchronous read. It holds an operand stack of `STK_DEPTH` words and an array of `NLOC` local-variable slots, and it runs until it reaches a return opcode, an opcode it does not support, or an illegal stack access.

The supported work is pushing a signed 8-bit immediate, pushing zero, moving words between the stack and local slots 1 to 3, and adding the top two stack words. On every stop the unit pulses `done` for one cycle. Two sticky flags tell a stack fault apart from an unsupported opcode, and both clear when the next run starts. Debug outputs give the selected local slot, the top of stack and the stack depth at any time, so the surrounding logic can collect results after `done`.

Top module: `bce_core`

## Requirements
- R1: After reset, `busy`, `done`, `err_stack` and `err_opcode` are 0, `depth` is 0, `tos` reads 0 and every local slot reads 0.
- R2: `start` is sampled only while idle. The run begins at `start_pc` and clears both error flags. A `start` pulse while busy has no effect on the run or its results.
- R3: Opcode 0x10 is two bytes long. It pushes the following code byte, sign-extended to `DW` bits.
- R4: Opcode 0x03 pushes the value 0.
- R5: Opcodes 0x3c, 0x3d and 0x3e pop the top of stack into local slots 1, 2 and 3 respectively.
- R6: Opcodes 0x1b and 0x1c push a copy of local slot 1 and local slot 2 respectively. The local is left unchanged.
- R7: Opcode 0x60 pops two words and pushes their sum modulo 2^DW, so depth drops by one.
- R8: Opcode 0xb1 stops execution with both error flags at 0. Every stop raises `done` for exactly one cycle, and `busy` falls in that same cycle.
- R9: A push onto a full stack, a pop from an empty stack, or 0x60 with fewer than two words sets `err_stack` and stops. The failing opcode changes neither the stack nor the locals.
- R10: Any other opcode value sets `err_opcode` and stops, with stack and locals unchanged.
- R11: `code_rd` is high only while busy, and read data is used one cycle after `code_rd`. Each one-byte opcode takes 2 cycles and 0x10 takes 3. `done` is seen N+1 rising edges after the edge that samples `start`, where N is the cycle total of the opcodes executed, the stopping opcode included.
- R12: `dbg_local` shows the slot chosen by `dbg_sel`, and `tos` and `depth` show the live stack. Their values hold while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | Begin a run (sampled while idle) |
| start_pc | input | AW | Code address of the first opcode |
| code_rd | output | 1 | Code memory read strobe |
| code_addr | output | AW | Code memory byte address |
| code_data | input | 8 | Code byte, valid the cycle after `code_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle stop pulse |
| err_stack | output | 1 | Stack overflow or underflow stopped the run |
| err_opcode | output | 1 | Unsupported opcode stopped the run |
| dbg_sel | input | $clog2(NLOC) | Local slot selected for `dbg_local` |
| dbg_local | output | DW | Value of the selected local slot |
| tos | output | DW | Top of stack (0 when empty) |
| depth | output | $clog2(STK_DEPTH+1) | Number of stack words |

## Verification
The bench builds the unit with a 4-word stack, 4 locals, 32-bit words and an 8-bit code address. The shallow stack makes overflow reachable within five pushes, on both the 0x03 path and the immediate cycle of 0x10. With 32-bit words, sign extension of 0x80 and 0xff can be checked against full-width values. Local slots carry over between runs, so the expected values in the vector table depend on the order in which the programs run.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam logic [7:0] OPC_PUSH_IMM = 8'h10;
  localparam logic [7:0] OPC_ZERO     = 8'h03;
  localparam logic [7:0] OPC_ST1      = 8'h3c;
  localparam logic [7:0] OPC_ST2      = 8'h3d;
  localparam logic [7:0] OPC_ST3      = 8'h3e;
  localparam logic [7:0] OPC_LD1      = 8'h1b;
  localparam logic [7:0] OPC_LD2      = 8'h1c;
  localparam logic [7:0] OPC_ADD      = 8'h60;
  localparam logic [7:0] OPC_RET      = 8'hb1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DEC,
    ST_IMM
  } run_state_e;

  typedef enum logic [2:0] {
    K_PUSH_IMM,
    K_ZERO,
    K_STORE,
    K_LOAD,
    K_ADD,
    K_RET,
    K_BAD
  } op_kind_e;

endpackage

// File: rtl/bce_decode.sv
module bce_decode
  import bce_pkg::*;
#(
  parameter int LW = 2
) (
  input  logic [7:0]    opc,
  output op_kind_e      kind,
  output logic [LW-1:0] slot
);

  logic [7:0] st_off;
  logic [7:0] ld_off;

  assign st_off = opc - 8'h3b;
  assign ld_off = opc - 8'h1a;

  always_comb begin
    kind = K_BAD;
    slot = '0;
    unique case (opc)
      OPC_PUSH_IMM: kind = K_PUSH_IMM;
      OPC_ZERO:     kind = K_ZERO;
      OPC_ST1, OPC_ST2, OPC_ST3: begin
        kind = K_STORE;
        slot = LW'(st_off[1:0]);
      end
      OPC_LD1, OPC_LD2: begin
        kind = K_LOAD;
        slot = LW'(ld_off[1:0]);
      end
      OPC_ADD:      kind = K_ADD;
      OPC_RET:      kind = K_RET;
      default:      kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/bce_stack.sv
module bce_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           push_en,
  input  logic [DW-1:0]  push_val,
  input  logic           pop_en,
  input  logic           add_en,
  output logic [DW-1:0]  tos,
  output logic [DW-1:0]  nos,
  output logic [SPW-1:0] depth
);

  logic [SPW-1:0]      sp_q, sp_n;
  logic [DW-1:0]       ent_q [DEPTH];
  logic                wr_en;
  logic [IW-1:0]       wr_idx;
  logic [DW-1:0]       wr_val;
  logic [DEPTH-1:0]    ent_we;
  logic [IW-1:0]       tos_idx, nos_idx;

  assign tos_idx = IW'(sp_q - SPW'(1));
  assign nos_idx = IW'(sp_q - SPW'(2));
  assign tos     = (sp_q != '0) ? ent_q[tos_idx] : '0;
  assign nos     = (sp_q > SPW'(1)) ? ent_q[nos_idx] : '0;
  assign depth   = sp_q;

  always_comb begin
    sp_n   = sp_q;
    wr_en  = 1'b0;
    wr_idx = IW'(sp_q);
    wr_val = push_val;
    if (clr) begin
      sp_n = '0;
    end else if (push_en) begin
      wr_en = 1'b1;
      sp_n  = sp_q + SPW'(1);
    end else if (pop_en) begin
      sp_n = sp_q - SPW'(1);
    end else if (add_en) begin
      wr_en  = 1'b1;
      wr_idx = nos_idx;
      wr_val = tos + nos;
      sp_n   = sp_q - SPW'(1);
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_we
    assign ent_we[gi] = wr_en && (wr_idx == IW'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) ent_q[i] <= wr_val;
    end
  end

endmodule

// File: rtl/bce_locals.sv
module bce_locals #(
  parameter int DW   = 32,
  parameter int NLOC = 4,
  localparam int LW  = $clog2(NLOC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic [LW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a,
  input  logic [LW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0]   slot_q [NLOC];
  logic [NLOC-1:0] slot_we;

  for (genvar gi = 0; gi < NLOC; gi++) begin : g_we
    assign slot_we[gi] = wr_en && (wr_idx == LW'(gi));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOC; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < NLOC; i++) begin
        if (slot_we[i]) slot_q[i] <= wr_val;
      end
    end
  end

  assign rd_a = slot_q[rd_a_idx];
  assign rd_b = slot_q[rd_b_idx];

endmodule

// File: rtl/bce_core.sv
module bce_core
  import bce_pkg::*;
#(
  parameter int DW        = 32,
  parameter int STK_DEPTH = 16,
  parameter int NLOC      = 4,
  parameter int AW        = 16,
  localparam int LW       = $clog2(NLOC),
  localparam int SPW      = $clog2(STK_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_pc,
  output logic           code_rd,
  output logic [AW-1:0]  code_addr,
  input  logic [7:0]     code_data,
  output logic           busy,
  output logic           done,
  output logic           err_stack,
  output logic           err_opcode,
  input  logic [LW-1:0]  dbg_sel,
  output logic [DW-1:0]  dbg_local,
  output logic [DW-1:0]  tos,
  output logic [SPW-1:0] depth
);

  initial begin
    if (NLOC < 4) $error("bce_core: NLOC must be at least 4");
    if (DW < 8)   $error("bce_core: DW must be at least 8");
  end

  run_state_e    st_q, st_n;
  logic [AW-1:0] pc_q, pc_n;
  logic          done_q, done_n;
  logic          es_q, es_n;
  logic          eo_q, eo_n;

  op_kind_e      kind;
  logic [LW-1:0] slot;

  logic          stk_clr, stk_push, stk_pop, stk_add;
  logic [DW-1:0] push_val;
  logic [DW-1:0] stk_tos, stk_nos;
  logic [SPW-1:0] stk_depth;
  logic          stk_full, stk_empty, stk_short;

  logic          lw_en;
  logic [DW-1:0] ld_val;

  bce_decode #(.LW(LW)) u_dec (
    .opc  (code_data),
    .kind (kind),
    .slot (slot)
  );

  bce_stack #(.DW(DW), .DEPTH(STK_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stk_clr),
    .push_en  (stk_push),
    .push_val (push_val),
    .pop_en   (stk_pop),
    .add_en   (stk_add),
    .tos      (stk_tos),
    .nos      (stk_nos),
    .depth    (stk_depth)
  );

  bce_locals #(.DW(DW), .NLOC(NLOC)) u_loc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (lw_en),
    .wr_idx   (slot),
    .wr_val   (stk_tos),
    .rd_a_idx (slot),
    .rd_a     (ld_val),
    .rd_b_idx (dbg_sel),
    .rd_b     (dbg_local)
  );

  assign stk_full  = (stk_depth == SPW'(STK_DEPTH));
  assign stk_empty = (stk_depth == '0);
  assign stk_short = (stk_depth < SPW'(2));

  // next-state process
  always_comb begin
    st_n      = st_q;
    pc_n      = pc_q;
    done_n    = 1'b0;
    es_n      = es_q;
    eo_n      = eo_q;
    code_rd   = 1'b0;
    code_addr = pc_q;
    stk_clr   = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_add   = 1'b0;
    push_val  = '0;
    lw_en     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          pc_n    = start_pc;
          es_n    = 1'b0;
          eo_n    = 1'b0;
          stk_clr = 1'b1;
          st_n    = ST_FETCH;
        end
      end

      ST_FETCH: begin
        code_rd = 1'b1;
        st_n    = ST_DEC;
      end

      ST_DEC: begin
        unique case (kind)
          K_PUSH_IMM: begin
            code_rd   = 1'b1;
            code_addr = pc_q + AW'(1);
            st_n      = ST_IMM;
          end
          K_ZERO: begin
            if (stk_full) begin
              es_n = 1'b1;
            end else begin
              stk_push = 1'b1;
              push_val = '0;
            end
          end
          K_STORE: begin
            if (stk_empty) begin
              es_n = 1'b1;
            end else begin
              stk_pop = 1'b1;
              lw_en   = 1'b1;
            end
          end
          K_LOAD: begin
            if (stk_full) begin
              es_n = 1'b1;
            end else begin
              stk_push = 1'b1;
              push_val = ld_val;
            end
          end
          K_ADD: begin
            if (stk_short) es_n = 1'b1;
            else           stk_add = 1'b1;
          end
          K_RET: begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
          default: begin
            eo_n   = 1'b1;
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        endcase
        if (kind == K_ZERO || kind == K_STORE || kind == K_LOAD || kind == K_ADD) begin
          if (es_n) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            pc_n = pc_q + AW'(1);
            st_n = ST_FETCH;
          end
        end
      end

      ST_IMM: begin
        if (stk_full) begin
          es_n   = 1'b1;
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          stk_push = 1'b1;
          push_val = {{(DW-8){code_data[7]}}, code_data};
          pc_n     = pc_q + AW'(2);
          st_n     = ST_FETCH;
        end
      end

      default: st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      done_q <= 1'b0;
      es_q   <= 1'b0;
      eo_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      pc_q   <= pc_n;
      done_q <= done_n;
      es_q   <= es_n;
      eo_q   <= eo_n;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign err_stack  = es_q;
  assign err_opcode = eo_q;
  assign tos        = stk_tos;
  assign depth      = stk_depth;

endmodule

// File: rtl/bce_core_chk.sv
module bce_core_chk #(
  parameter int DW        = 32,
  parameter int STK_DEPTH = 16,
  parameter int NLOC      = 4,
  parameter int AW        = 16,
  localparam int LW       = $clog2(NLOC),
  localparam int SPW      = $clog2(STK_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           code_rd,
  input logic           busy,
  input logic           done,
  input logic           err_stack,
  input logic           err_opcode,
  input logic [DW-1:0]  tos,
  input logic [SPW-1:0] depth
);

  // R8: stop pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: leaving the busy state always comes with done
  a_r8_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: stack never grows past its capacity
  a_r9_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= SPW'(STK_DEPTH));

  // R9: a stack fault ends the run in the same cycle
  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_stack) |-> (done && !busy));

  // R10: an unsupported opcode ends the run in the same cycle
  a_r10_bad_op_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_opcode) |-> (done && !busy));

  // R11: code memory is read only during a run
  a_r11_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    code_rd |-> busy);

  // R12: stack view holds while idle without start
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(depth) && $stable(tos)));

endmodule

bind bce_core bce_core_chk #(
  .DW(DW), .STK_DEPTH(STK_DEPTH), .NLOC(NLOC), .AW(AW)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .code_rd    (code_rd),
  .busy       (busy),
  .done       (done),
  .err_stack  (err_stack),
  .err_opcode (err_opcode),
  .tos        (tos),
  .depth      (depth)
);

// File: tb/bce_core_tb_top.sv
`timescale 1ns/1ps
module bce_core_tb_top;

  localparam int DW = 32, SD = 4, NL = 4, AW = 8;
  localparam int LW = $clog2(NL), SPW = $clog2(SD + 1);

  typedef struct packed {
    logic [7:0]  pc;
    logic [31:0] l1, l2, l3, tv;
    logic [3:0]  dep;
    logic        es, eo;
    logic [7:0]  cyc;
  } vec_t;

  // programs run in this order; locals carry between runs
  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{8'h00, 32'd15, 32'd9, 32'd24, 32'd0, 4'd0, 1'b0, 1'b0, 8'd25},      // example sequence
    '{8'h20, 32'd3, 32'd9, 32'd24, 32'd3, 4'd1, 1'b0, 1'b0, 8'd15},       // -2+5, store, reload
    '{8'h30, 32'd3, 32'hFFFFFF80, 32'd24, 32'h82, 4'd1, 1'b0, 1'b0, 8'd15}, // R3 sign ext
    '{8'h40, 32'd3, 32'hFFFFFF80, 32'd24, 32'd0, 4'd0, 1'b1, 1'b0, 8'd3},  // add on empty
    '{8'h48, 32'd3, 32'hFFFFFF80, 32'd24, 32'd0, 4'd0, 1'b1, 1'b0, 8'd3},  // store on empty
    '{8'h50, 32'd3, 32'hFFFFFF80, 32'd24, 32'd0, 4'd4, 1'b1, 1'b0, 8'd11}, // R4 overflow
    '{8'h60, 32'd3, 32'hFFFFFF80, 32'd24, 32'd0, 4'd1, 1'b0, 1'b1, 8'd5},  // bad opcode
    '{8'h68, 32'd3, 32'hFFFFFF80, 32'd24, 32'd7, 4'd1, 1'b1, 1'b0, 8'd6},  // add with one word
    '{8'h70, 32'd3, 32'hFFFFFF80, 32'd24, 32'd0, 4'd4, 1'b1, 1'b0, 8'd12}  // overflow on immediate
  };

  logic           clk, rst_n, start;
  logic [AW-1:0]  start_pc, code_addr;
  logic           code_rd, busy, done, err_stack, err_opcode;
  logic [7:0]     code_data;
  logic [LW-1:0]  dbg_sel;
  logic [DW-1:0]  dbg_local, tos;
  logic [SPW-1:0] depth;
  logic [7:0]     cmem [256];

  int n_chk, n_fail;
  bit finished;

  bce_core #(.DW(DW), .STK_DEPTH(SD), .NLOC(NL), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .code_rd(code_rd), .code_addr(code_addr), .code_data(code_data),
    .busy(busy), .done(done), .err_stack(err_stack), .err_opcode(err_opcode),
    .dbg_sel(dbg_sel), .dbg_local(dbg_local), .tos(tos), .depth(depth)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // synchronous-read code memory model
  always @(posedge clk) if (code_rd) code_data <= cmem[code_addr];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] b);
    cmem[a] = b;
  endtask

  // run from pc; optionally pulse start with other_pc at cycle poke
  task automatic run(input logic [7:0] pc, input int poke, input logic [7:0] other_pc,
                     output int cyc, output bit one_shot);
    @(negedge clk);
    start_pc = pc; start = 1'b1;
    @(posedge clk); cyc = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 300) begin
      if (cyc == poke) begin start_pc = other_pc; start = 1'b1; end
      else start = 1'b0;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    one_shot = !done;
  endtask

  task automatic read_local(input int s, output logic [31:0] v);
    dbg_sel = LW'(s);
    #1 v = dbg_local;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc;
    bit os;
    logic [31:0] v;
    n_chk = 0; n_fail = 0; finished = 0;
    for (int i = 0; i < 256; i++) cmem[i] = 8'h00;
    // example sequence at 0x00
    put(8'h00, 8'h10); put(8'h01, 8'h0f); put(8'h02, 8'h3c); put(8'h03, 8'h10);
    put(8'h04, 8'h09); put(8'h05, 8'h3d); put(8'h06, 8'h03); put(8'h07, 8'h3e);
    put(8'h08, 8'h1b); put(8'h09, 8'h1c); put(8'h0a, 8'h60); put(8'h0b, 8'h3e);
    put(8'h0c, 8'hb1);
    put(8'h20, 8'h10); put(8'h21, 8'hfe); put(8'h22, 8'h10); put(8'h23, 8'h05);
    put(8'h24, 8'h60); put(8'h25, 8'h3c); put(8'h26, 8'h1b); put(8'h27, 8'hb1);
    put(8'h30, 8'h10); put(8'h31, 8'h80); put(8'h32, 8'h3d); put(8'h33, 8'h10);
    put(8'h34, 8'h7f); put(8'h35, 8'h1b); put(8'h36, 8'h60); put(8'h37, 8'hb1);
    put(8'h40, 8'h60); put(8'h41, 8'hb1);
    put(8'h48, 8'h3e); put(8'h49, 8'hb1);
    for (int i = 0; i < 5; i++) put(8'h50 + i, 8'h03);
    put(8'h55, 8'hb1);
    put(8'h60, 8'h03); put(8'h61, 8'hff); put(8'h62, 8'hb1);
    put(8'h68, 8'h10); put(8'h69, 8'h07); put(8'h6a, 8'h60); put(8'h6b, 8'hb1);
    for (int i = 0; i < 4; i++) put(8'h70 + i, 8'h03);
    put(8'h74, 8'h10); put(8'h75, 8'h05); put(8'h76, 8'hb1);
    put(8'h78, 8'h10); put(8'h79, 8'hff); put(8'h7a, 8'hb1);
    put(8'h7c, 8'h10); put(8'h7d, 8'h05); put(8'h7e, 8'h03); put(8'h7f, 8'hb1);
    put(8'h80, 8'h1c); put(8'h81, 8'h1b); put(8'h82, 8'hb1);

    rst_n = 1'b0; start = 1'b0; start_pc = '0; dbg_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "busy", 32'(busy), 0);
    check("R1", "done", 32'(done), 0);
    check("R1", "errors", {30'd0, err_stack, err_opcode}, 0);
    check("R1", "depth", 32'(depth), 0);
    check("R1", "tos", tos, 0);
    for (int s = 0; s < NL; s++) begin
      read_local(s, v);
      check("R1", "local", v, 0);
    end

    for (int k = 0; k < NV; k++) begin
      run(VT[k].pc, -1, 8'h00, cyc, os);
      check("R11", "cycles to done", 32'(cyc), 32'(VT[k].cyc));
      check("R8", "done single pulse", 32'(os), 1);
      read_local(1, v); check("R5", "local1", v, VT[k].l1);
      read_local(2, v); check("R5", "local2", v, VT[k].l2);
      read_local(3, v); check("R5", "local3", v, VT[k].l3);
      check("R7", "tos", tos, VT[k].tv);
      check("R12", "depth", 32'(depth), 32'(VT[k].dep));
      check("R9", "err_stack", 32'(err_stack), 32'(VT[k].es));
      check("R10", "err_opcode", 32'(err_opcode), 32'(VT[k].eo));
    end

    // R3: 0xff sign-extends to all ones
    run(8'h78, -1, 8'h00, cyc, os);
    check("R3", "tos after push 0xff", tos, 32'hFFFFFFFF);
    check("R8", "errors clear after clean stop", {30'd0, err_stack, err_opcode}, 0);
    // R4: zero pushed over a nonzero word
    run(8'h7c, -1, 8'h00, cyc, os);
    check("R4", "tos after push zero", tos, 0);
    check("R4", "depth after two pushes", 32'(depth), 2);
    // R6: loads copy locals 2 then 1
    run(8'h80, -1, 8'h00, cyc, os);
    check("R6", "tos is local1", tos, 32'd3);
    check("R6", "depth after loads", 32'(depth), 2);
    read_local(2, v); check("R6", "local2 kept", v, 32'hFFFFFF80);
    // R2: start while busy is ignored
    run(8'h00, 6, 8'h40, cyc, os);
    check("R2", "cycles with stray start", 32'(cyc), 25);
    check("R2", "no fault from stray start", 32'(err_stack), 0);
    read_local(3, v); check("R2", "local3 result", v, 32'd24);
    read_local(0, v); check("R12", "local0 untouched", v, 0);
    repeat (3) @(negedge clk);
    check("R12", "idle depth holds", 32'(depth), 0);
    check("R2", "stays idle", 32'(busy), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule